// File: doc/BRIEF.md
# Split-Word Multi-Channel Increment Loader

This block sits on a 16-bit write bus and fills the wide phase-increment registers of a bank of numerically controlled oscillators. Each channel has a 26-bit carrier increment and a 25-bit code increment. A 16-bit bus cannot set either one in a single write, so software first writes the upper bits to a HIGH address, where they wait in a holding buffer. It then writes the lower 16 bits to a LOW address. The LOW write joins the buffer with its own data and loads the whole word into the target register in one clock edge, so the oscillator never runs on a half-updated increment.

A LOW write can reach one channel, every channel named in a channel-select mask, or all channels at once. The carrier path and the code path each have their own holding buffer. A buffer keeps its contents after a commit, so a run of LOW writes can reuse the same upper bits. Each path has a small commit state machine with two states, ST_IDLE and ST_COMMIT. A LOW write moves it to ST_COMMIT, or keeps it there. Any other cycle returns it to ST_IDLE. While it is in ST_COMMIT, the path drives a one-cycle update strobe for every channel that has just been loaded.

Address layout: bits [7:4] select a group and bits [1:0] select a register; bits [3:2] must be zero. Groups 0 to NUM_CH-1 address a single channel. Group 13 is the channel-select mask, group 14 is multi-channel and group 15 is all-channel. The register codes are 0 for carrier HIGH, 1 for carrier LOW, 2 for code HIGH and 3 for code LOW.

Top module: `incr_loader`

## Requirements
- R1: After reset, every increment register reads zero, every update strobe is low, and the channel-select mask is zero.
- R2: A carrier HIGH write (register code 0) stores data bits 9..0 as carrier increment bits 25..16 and ignores data bits 15..10. The write itself changes no increment and raises no strobe.
- R3: A code HIGH write (register code 2) stores data bits 8..0 as code increment bits 24..16 and ignores data bits 15..9. The write itself changes no increment and raises no strobe.
- R4: A per-channel LOW write to group g loads {holding buffer, data[15:0]} into the increment register of channel g only. The new value is visible in the cycle after the write.
- R5: A HIGH write to a per-channel, multi-channel or all-channel group loads the same holding buffer of its path.
- R6: A write of register code 0 to group 13 sets the channel-select mask from data bits NUM_CH-1..0. A multi-channel LOW write (group 14) then loads exactly the channels whose mask bit is 1.
- R7: An all-channel LOW write (group 15) loads every channel of that path.
- R8: The carrier and code buffers are independent of each other. Each buffer keeps its value after a commit, so repeated LOW writes reuse the last HIGH bits.
- R9: Writes with the write enable low, writes with address bits [3:2] not zero, and writes to groups NUM_CH..12 change no register and raise no strobe.
- R10: An update strobe is high for exactly the cycle after the LOW write that loaded its channel. It stays high across back-to-back LOW writes and is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Write address (group, padding, register code) |
| wr_data | input | DATA_W | Write data |
| car_incr | output | NUM_CH*CAR_W | Carrier increments; channel c is at [c*CAR_W +: CAR_W] |
| car_upd | output | NUM_CH | Carrier update strobes, one bit per channel |
| cod_incr | output | NUM_CH*COD_W | Code increments; channel c is at [c*COD_W +: COD_W] |
| cod_upd | output | NUM_CH | Code update strobes, one bit per channel |

## Verification
The assertions assume at most one write per cycle, so a HIGH write and a LOW write never share a clock edge. They also assume that the write inputs are stable and known around every rising edge once reset has been released. The bench changes the inputs only on falling edges, through a single task that issues one address, one data word and one enable per cycle. Random addresses are drawn from valid groups, unused groups and non-zero padding, and the write enable is dropped about one cycle in eight.

// File: rtl/incr_pkg.sv
package incr_pkg;

    // Register code in address bits [1:0]
    typedef enum logic [1:0] {
        REG_CAR_HI = 2'd0,
        REG_CAR_LO = 2'd1,
        REG_COD_HI = 2'd2,
        REG_COD_LO = 2'd3
    } reg_sel_e;

    // Group codes in the top four address bits
    localparam logic [3:0] GRP_MASK  = 4'd13;
    localparam logic [3:0] GRP_MULTI = 4'd14;
    localparam logic [3:0] GRP_ALL   = 4'd15;

    // Commit sequencer state of one increment path
    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_COMMIT = 1'b1
    } commit_state_e;

endpackage

// File: rtl/incr_decode.sv
module incr_decode
    import incr_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              car_hi_we,
    output logic              car_lo_we,
    output logic              cod_hi_we,
    output logic              cod_lo_we,
    output logic [NUM_CH-1:0] lo_target
);

    localparam int PAD_HI = ADDR_W - 5;

    logic [3:0]        grp;
    reg_sel_e          sel;
    logic              pad_ok;
    logic              grp_is_ch;
    logic              grp_valid;
    logic              mask_we;
    logic [NUM_CH-1:0] ch_onehot;
    logic [NUM_CH-1:0] mask_q;

    assign grp    = wr_addr[ADDR_W-1 -: 4];
    assign sel    = reg_sel_e'(wr_addr[1:0]);
    assign pad_ok = (wr_addr[PAD_HI:2] == '0);

    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            ch_onehot[i] = (grp == 4'(i));
        end
    end

    assign grp_is_ch = |ch_onehot;
    assign grp_valid = grp_is_ch || (grp == GRP_MULTI) || (grp == GRP_ALL);

    always_comb begin
        if (grp_is_ch) begin
            lo_target = ch_onehot;
        end else if (grp == GRP_MULTI) begin
            lo_target = mask_q;
        end else if (grp == GRP_ALL) begin
            lo_target = '1;
        end else begin
            lo_target = '0;
        end
    end

    always_comb begin
        car_hi_we = 1'b0;
        car_lo_we = 1'b0;
        cod_hi_we = 1'b0;
        cod_lo_we = 1'b0;
        if (wr_en && pad_ok && grp_valid) begin
            unique case (sel)
                REG_CAR_HI: car_hi_we = 1'b1;
                REG_CAR_LO: car_lo_we = 1'b1;
                REG_COD_HI: cod_hi_we = 1'b1;
                REG_COD_LO: cod_lo_we = 1'b1;
            endcase
        end
    end

    assign mask_we = wr_en && pad_ok && (grp == GRP_MASK) && (sel == REG_CAR_HI);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_we) begin
            mask_q <= wr_data[NUM_CH-1:0];
        end
    end

endmodule

// File: rtl/incr_path.sv
module incr_path
    import incr_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int INC_W  = 26,
    parameter int DATA_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hi_we,
    input  logic                    lo_we,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic [NUM_CH-1:0]       lo_target,
    output logic [NUM_CH*INC_W-1:0] incr_flat,
    output logic [NUM_CH-1:0]       upd
);

    localparam int HI_W = INC_W - DATA_W;

    logic [HI_W-1:0]   hi_buf_q;
    commit_state_e     state_q;
    commit_state_e     state_d;
    logic [NUM_CH-1:0] commit_mask_q;

    // Holding buffer: only the low HI_W data bits are kept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_buf_q <= '0;
        end else if (hi_we) begin
            hi_buf_q <= wr_data[HI_W-1:0];
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = lo_we ? ST_COMMIT : ST_IDLE;
            ST_COMMIT: state_d = lo_we ? ST_COMMIT : ST_IDLE;
        endcase
    end

    // State register and the channel set of the latest commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ST_IDLE;
            commit_mask_q <= '0;
        end else begin
            state_q <= state_d;
            if (lo_we) begin
                commit_mask_q <= lo_target;
            end
        end
    end

    // Outputs from state
    always_comb begin
        upd = '0;
        unique case (state_q)
            ST_IDLE:   upd = '0;
            ST_COMMIT: upd = commit_mask_q;
        endcase
    end

    // Per-channel increment registers
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic [INC_W-1:0] incr_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                incr_q <= '0;
            end else if (lo_we && lo_target[ch]) begin
                incr_q <= {hi_buf_q, wr_data};
            end
        end

        assign incr_flat[ch*INC_W +: INC_W] = incr_q;
    end

endmodule

// File: rtl/incr_loader.sv
module incr_loader #(
    parameter int NUM_CH = 4,
    parameter int CAR_W  = 26,
    parameter int COD_W  = 25,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    output logic [NUM_CH*CAR_W-1:0] car_incr,
    output logic [NUM_CH-1:0]       car_upd,
    output logic [NUM_CH*COD_W-1:0] cod_incr,
    output logic [NUM_CH-1:0]       cod_upd
);

    logic              car_hi_we;
    logic              car_lo_we;
    logic              cod_hi_we;
    logic              cod_lo_we;
    logic [NUM_CH-1:0] lo_target;

    incr_decode #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .car_hi_we (car_hi_we),
        .car_lo_we (car_lo_we),
        .cod_hi_we (cod_hi_we),
        .cod_lo_we (cod_lo_we),
        .lo_target (lo_target)
    );

    incr_path #(
        .NUM_CH (NUM_CH),
        .INC_W  (CAR_W),
        .DATA_W (DATA_W)
    ) u_car_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .hi_we     (car_hi_we),
        .lo_we     (car_lo_we),
        .wr_data   (wr_data),
        .lo_target (lo_target),
        .incr_flat (car_incr),
        .upd       (car_upd)
    );

    incr_path #(
        .NUM_CH (NUM_CH),
        .INC_W  (COD_W),
        .DATA_W (DATA_W)
    ) u_cod_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .hi_we     (cod_hi_we),
        .lo_we     (cod_lo_we),
        .wr_data   (wr_data),
        .lo_target (lo_target),
        .incr_flat (cod_incr),
        .upd       (cod_upd)
    );

endmodule

// File: rtl/incr_loader_chk.sv
module incr_loader_chk #(
    parameter int NUM_CH = 4,
    parameter int CAR_W  = 26,
    parameter int COD_W  = 25,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_en,
    input logic [ADDR_W-1:0]       wr_addr,
    input logic [DATA_W-1:0]       wr_data,
    input logic [NUM_CH*CAR_W-1:0] car_incr,
    input logic [NUM_CH-1:0]       car_upd,
    input logic [NUM_CH*COD_W-1:0] cod_incr,
    input logic [NUM_CH-1:0]       cod_upd
);

    logic [3:0] grp;
    logic       pad_ok;
    logic       car_lo_all;
    logic       cod_lo_all;
    logic       car_lo_one;

    assign grp        = wr_addr[ADDR_W-1 -: 4];
    assign pad_ok     = (wr_addr[ADDR_W-5:2] == '0);
    assign car_lo_all = wr_en && pad_ok && (grp == 4'd15) && (wr_addr[1:0] == 2'd1);
    assign cod_lo_all = wr_en && pad_ok && (grp == 4'd15) && (wr_addr[1:0] == 2'd3);
    assign car_lo_one = wr_en && pad_ok && (32'(grp) < NUM_CH) && (wr_addr[1:0] == 2'd1);

    p_car_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (car_upd == '0) |-> $stable(car_incr));

    p_cod_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cod_upd == '0) |-> $stable(cod_incr));

    p_car_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        car_lo_one |=> ($countones(car_upd) == 1));

    p_car_hi_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[1:0] == 2'd0) |=> (car_upd == '0 && cod_upd == '0));

    p_cod_hi_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[1:0] == 2'd2) |=> (car_upd == '0 && cod_upd == '0));

    p_car_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
        car_lo_all |=> (car_upd == '1));

    p_cod_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cod_lo_all |=> (cod_upd == '1));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (car_upd == '0 && cod_upd == '0));

    p_strobe_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (car_upd != '0 && !wr_en) |=> (car_upd == '0));

endmodule

bind incr_loader incr_loader_chk #(
    .NUM_CH (NUM_CH),
    .CAR_W  (CAR_W),
    .COD_W  (COD_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .car_incr (car_incr),
    .car_upd  (car_upd),
    .cod_incr (cod_incr),
    .cod_upd  (cod_upd)
);

// File: tb/incr_loader_bench.sv
module incr_loader_bench;

    localparam int NUM_CH = 4;
    localparam int CAR_W  = 26;
    localparam int COD_W  = 25;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    wr_en = 1'b0;
    logic [ADDR_W-1:0]       wr_addr = '0;
    logic [DATA_W-1:0]       wr_data = '0;
    logic [NUM_CH*CAR_W-1:0] car_incr;
    logic [NUM_CH-1:0]       car_upd;
    logic [NUM_CH*COD_W-1:0] cod_incr;
    logic [NUM_CH-1:0]       cod_upd;

    int n_checks = 0;
    int n_fail   = 0;

    // Reference state
    logic [CAR_W-1:0]  m_car [NUM_CH];
    logic [COD_W-1:0]  m_cod [NUM_CH];
    logic [9:0]        m_car_hi;
    logic [8:0]        m_cod_hi;
    logic [NUM_CH-1:0] m_mask;
    logic [NUM_CH-1:0] e_car_upd;
    logic [NUM_CH-1:0] e_cod_upd;

    always #2.5 clk = ~clk;

    incr_loader #(
        .NUM_CH (NUM_CH),
        .CAR_W  (CAR_W),
        .COD_W  (COD_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_incr_loader (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .car_incr (car_incr),
        .car_upd  (car_upd),
        .cod_incr (cod_incr),
        .cod_upd  (cod_upd)
    );

    function automatic logic [7:0] adr(input logic [3:0] g, input logic [1:0] r);
        return {g, 2'b00, r};
    endfunction

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    task automatic check_eq(input string tag, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int ch = 0; ch < NUM_CH; ch++) begin
            m_car[ch] = '0;
            m_cod[ch] = '0;
        end
        m_car_hi  = '0;
        m_cod_hi  = '0;
        m_mask    = '0;
        e_car_upd = '0;
        e_cod_upd = '0;
    endtask

    task automatic model_write(input logic en, input logic [7:0] a, input logic [15:0] d);
        logic [NUM_CH-1:0] tgt;
        logic [3:0]        g;
        e_car_upd = '0;
        e_cod_upd = '0;
        g = a[7:4];
        if (!en || a[3:2] != 2'b00) return;
        if (g == 4'd13) begin
            if (a[1:0] == 2'd0) m_mask = d[NUM_CH-1:0];
            return;
        end
        if (int'(g) < NUM_CH)  tgt = NUM_CH'(1) << g;
        else if (g == 4'd14)   tgt = m_mask;
        else if (g == 4'd15)   tgt = '1;
        else return;
        case (a[1:0])
            2'd0: m_car_hi = d[9:0];
            2'd1: begin
                for (int ch = 0; ch < NUM_CH; ch++)
                    if (tgt[ch]) m_car[ch] = {m_car_hi, d};
                e_car_upd = tgt;
            end
            2'd2: m_cod_hi = d[8:0];
            default: begin
                for (int ch = 0; ch < NUM_CH; ch++)
                    if (tgt[ch]) m_cod[ch] = {m_cod_hi, d};
                e_cod_upd = tgt;
            end
        endcase
    endtask

    task automatic check_outputs(input string tag);
        for (int ch = 0; ch < NUM_CH; ch++) begin
            check_eq(tag, $sformatf("car_incr[%0d]", ch), 32'(car_incr[ch*CAR_W +: CAR_W]), 32'(m_car[ch]));
            check_eq(tag, $sformatf("cod_incr[%0d]", ch), 32'(cod_incr[ch*COD_W +: COD_W]), 32'(m_cod[ch]));
        end
        check_eq(tag, "car_upd", 32'(car_upd), 32'(e_car_upd));
        check_eq(tag, "cod_upd", 32'(cod_upd), 32'(e_cod_upd));
    endtask

    // One bus cycle: drive at a falling edge, check at the next one
    task automatic step(input logic en, input logic [7:0] a, input logic [15:0] d, input string tag);
        wr_en   = en;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        model_write(en, a, d);
        check_outputs(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h1A2B3C4D);
        model_reset();
        repeat (3) @(negedge clk);
        check_outputs("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_outputs("R1 after reset");

        // R2: carrier HIGH drops bits 15..10, then a per-channel LOW commits
        step(1'b1, adr(4'd0, 2'd0), 16'hFFFF, "R2 carrier high");
        step(1'b1, adr(4'd2, 2'd1), 16'h1234, "R4 single channel low");
        check_eq("R2", "car_incr[2] value", 32'(car_incr[2*CAR_W +: CAR_W]), 32'h03FF_1234);
        step(1'b0, 8'h00, 16'h0000, "R10 strobe drop");

        // R3: code HIGH drops bits 15..9
        step(1'b1, adr(4'd1, 2'd2), 16'hFFFF, "R3 code high");
        step(1'b1, adr(4'd1, 2'd3), 16'hABCD, "R4 code low");
        check_eq("R3", "cod_incr[1] value", 32'(cod_incr[1*COD_W +: COD_W]), 32'h01FF_ABCD);

        // R5: HIGH through the all-channel and multi-channel addresses
        step(1'b1, adr(4'd15, 2'd0), 16'h0155, "R5 high via all");
        step(1'b1, adr(4'd3, 2'd1), 16'h0001, "R5 low ch3");
        check_eq("R5", "car_incr[3] value", 32'(car_incr[3*CAR_W +: CAR_W]), 32'h0155_0001);
        step(1'b1, adr(4'd14, 2'd2), 16'h00AA, "R5 high via multi");
        step(1'b1, adr(4'd0, 2'd3), 16'h0002, "R5 code low ch0");
        check_eq("R5", "cod_incr[0] value", 32'(cod_incr[0*COD_W +: COD_W]), 32'h00AA_0002);

        // R6: mask then multi-channel LOW
        step(1'b1, adr(4'd13, 2'd0), 16'h000A, "R6 mask write");
        step(1'b1, adr(4'd14, 2'd1), 16'h7777, "R6 multi low");
        check_eq("R6", "car_upd mask", 32'(car_upd), 32'h0000_000A);

        // R7: all-channel code LOW
        step(1'b1, adr(4'd15, 2'd3), 16'h4242, "R7 all low");
        check_eq("R7", "cod_upd all", 32'(cod_upd), 32'h0000_000F);

        // R8: code HIGH leaves the carrier buffer; repeated LOW reuses it
        step(1'b1, adr(4'd2, 2'd2), 16'h0033, "R8 code high");
        step(1'b1, adr(4'd0, 2'd1), 16'h5555, "R8 reuse carrier buffer");
        check_eq("R8", "car_incr[0] value", 32'(car_incr[0*CAR_W +: CAR_W]), 32'h0155_5555);

        // R9: disabled, padded and unused-group writes
        step(1'b0, adr(4'd0, 2'd1), 16'hDEAD, "R9 enable low");
        step(1'b1, {4'd0, 2'b01, 2'd1}, 16'hBEEF, "R9 padding set");
        step(1'b1, adr(4'd9, 2'd1), 16'hCAFE, "R9 unused group");
        step(1'b1, adr(4'd9, 2'd0), 16'h03FF, "R9 unused group high");
        step(1'b1, adr(4'd1, 2'd1), 16'h0000, "R9 buffer untouched");
        check_eq("R9", "car_incr[1] value", 32'(car_incr[1*CAR_W +: CAR_W]), 32'h0155_0000);

        // R10: back-to-back LOW writes keep the strobe up, then it drops
        step(1'b1, adr(4'd3, 2'd1), 16'h1111, "R10 first low");
        step(1'b1, adr(4'd3, 2'd1), 16'h2222, "R10 second low");
        check_eq("R10", "car_upd held", 32'(car_upd), 32'h0000_0008);
        step(1'b0, 8'h00, 16'h0000, "R10 strobe low");
        check_eq("R10", "car_upd low", 32'(car_upd), 32'h0);

        // Random mix
        for (int i = 0; i < 600; i++) begin
            logic       en;
            logic [3:0] g;
            logic [1:0] pad;
            logic [7:0] a;
            int         pick;
            en   = (($urandom % 8) != 0);
            pick = $urandom % 10;
            if (pick < 4)       g = 4'(pick);
            else if (pick == 4) g = 4'd13;
            else if (pick < 7)  g = 4'd14;
            else if (pick < 9)  g = 4'd15;
            else                g = 4'(5 + ($urandom % 8));
            pad = (($urandom % 12) == 0) ? 2'($urandom) : 2'b00;
            a   = {g, pad, 2'($urandom)};
            step(en, a, 16'($urandom), "random R4 R5 R6 R7 R8 R9 R10");
        end

        wr_en = 1'b0;
        @(negedge clk);
        report();
    end

endmodule